// File: doc/BRIEF.md
# Step Clock Acquisition Filter

This block sits between an asynchronous step-clock pin and a stepping-motor phase sequencer. It brings the step clock, the edge-select input, the direction input and the excitation-mode inputs into the system clock domain through two-flop synchronisers. It then passes the step clock through a shift-register glitch filter that accepts a new level only after a configurable number of consecutive equal samples. Each accepted transition that the edge-select setting allows becomes a one-cycle step strobe.

Direction and mode are not followed continuously. They are captured only at the moment a qualifying edge is accepted, which is a fixed number of cycles after the pin changes. Those two values are presented one cycle before the strobe, so the sequencer sees the new setting together with the step it applies to. The input settling times the motor-driver convention allows around clock edges (several microseconds) fit comfortably around this capture point.

A low enable stands in for a stopped system clock. All internal state freezes and no strobe leaves the block.

Top module: `stepclk_acq`

## Requirements
- R1: After a synchronous reset, step_o, dir_o and mode_o are 0. The filtered step level and the synchronisers start at the idle-high level, so a pin held high after reset yields no step.
- R2: With one_edge_i = 1, only filtered low-to-high transitions of step_i produce a strobe. Filtered falling transitions are absorbed silently.
- R3: With one_edge_i = 0, every filtered transition produces a strobe: two strobes per full step_i period.
- R4: A step_i level that persists for fewer than FILT_LEN consecutive system-clock samples changes nothing. A level that persists for exactly FILT_LEN samples is accepted.
- R5: When step_i changes before clock edge t0 and then stays put, a strobe that qualifies appears as step_o high for the single cycle after edge t0+FILT_LEN+3.
- R6: On a qualifying acceptance, dir_o and mode_o take the values dir_i and mode_i held at clock edge t0+FILT_LEN. They change one cycle before the matching step_o pulse.
- R7: Changes on dir_i and mode_i that are not captured by a qualifying acceptance leave dir_o and mode_o unchanged.
- R8: While enable_i is low, no state advances, step_o stays 0, and step_i changes are not counted. After release, a level changed during the hold is filtered normally. A strobe that was pending when enable fell is issued at the first enabled edge.
- R9: step_o is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | High = run, low = hold (state frozen, no strobes) |
| step_i | input | 1 | Asynchronous step clock |
| one_edge_i | input | 1 | 1 = rising edges only count, 0 = both edges count (asynchronous) |
| dir_i | input | 1 | Asynchronous rotation direction |
| mode_i | input | MODE_W | Asynchronous excitation-mode code |
| step_o | output | 1 | One-cycle step strobe |
| dir_o | output | 1 | Direction captured with the latest strobe |
| mode_o | output | MODE_W | Mode captured with the latest strobe |

## Verification
The hardest situation to reach from the ports is a step that has already been accepted inside the filter while its strobe has not yet left the block, with the hold input taken low in exactly that cycle. The stimulus changes step_i and counts FILT_LEN+3 falling edges, so that the acceptance edge has passed. It then drops enable_i, holds it low, releases it, and expects the deferred strobe on the very next cycle. Spike widths of FILT_LEN-1 and FILT_LEN samples bracket the filter threshold. A direction change placed one cycle after the capture point shows that the capture point is exactly where R6 puts it.

// File: rtl/stepacq_pkg.sv
package stepacq_pkg;
  // Edge counting policy as seen on the edge-select input
  typedef enum logic {
    EDGE_BOTH = 1'b0,
    EDGE_RISE = 1'b1
  } edge_policy_e;

  // Idle level of the step input (pulled up when open)
  localparam logic STEP_IDLE = 1'b1;
endpackage

// File: rtl/stepacq_sync.sv
// Two-stage synchroniser bank with hold and per-bit reset value
module stepacq_sync #(
  parameter int          W       = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      stab_q <= RST_VAL;
    end else if (en) begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/stepacq_filter.sv
// Shift-register glitch filter: level accepted after LEN equal samples
module stepacq_filter #(
  parameter int   LEN  = 8,
  parameter logic IDLE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic din,
  output logic lvl_o,
  output logic chg_o,
  output logic rise_o
);
  logic [LEN-1:0] hist_q;
  logic           lvl_q;
  logic           all_hi;
  logic           all_lo;

  generate
    if (LEN == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst)     hist_q <= {LEN{IDLE}};
        else if (en) hist_q <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst)     hist_q <= {LEN{IDLE}};
        else if (en) hist_q <= {hist_q[LEN-2:0], din};
      end
    end
  endgenerate

  assign all_hi = &hist_q;
  assign all_lo = ~|hist_q;
  assign chg_o  = en && ((all_hi && !lvl_q) || (all_lo && lvl_q));
  assign rise_o = all_hi;

  always_ff @(posedge clk) begin
    if (rst)        lvl_q <= IDLE;
    else if (chg_o) lvl_q <= all_hi;
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/stepacq_qual.sv
// Edge qualification, direction/mode capture, delayed step strobe
module stepacq_qual
  import stepacq_pkg::*;
#(
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              chg,
  input  logic              rise,
  input  edge_policy_e      policy,
  input  logic              dir_s,
  input  logic [MODE_W-1:0] mode_s,
  output logic              step_o,
  output logic              dir_o,
  output logic [MODE_W-1:0] mode_o
);
  logic              take;
  logic              pend_q;
  logic              step_q;
  logic              dir_q;
  logic [MODE_W-1:0] mode_q;

  assign take = chg && (rise || (policy == EDGE_BOTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      dir_q  <= 1'b0;
      mode_q <= '0;
    end else if (en) begin
      pend_q <= take;
      if (take) begin
        dir_q  <= dir_s;
        mode_q <= mode_s;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     step_q <= 1'b0;
    else if (en) step_q <= pend_q;
    else         step_q <= 1'b0;
  end

  assign step_o = step_q;
  assign dir_o  = dir_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/stepclk_acq.sv
module stepclk_acq
  import stepacq_pkg::*;
#(
  parameter int FILT_LEN = 8,
  parameter int MODE_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable_i,
  input  logic              step_i,
  input  logic              one_edge_i,
  input  logic              dir_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              step_o,
  output logic              dir_o,
  output logic [MODE_W-1:0] mode_o
);
  localparam int SW = MODE_W + 3;
  localparam logic [SW-1:0] SYNC_RST = {STEP_IDLE, 1'b1, 1'b0, {MODE_W{1'b0}}};

  logic [SW-1:0]     sync_d;
  logic [SW-1:0]     sync_q;
  logic              step_s;
  logic              edge_s;
  logic              dir_s;
  logic [MODE_W-1:0] mode_s;
  logic              filt_lvl;
  logic              filt_chg;
  logic              filt_rise;
  edge_policy_e      policy;

  assign sync_d = {step_i, one_edge_i, dir_i, mode_i};

  stepacq_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
    .clk (clk),
    .rst (rst),
    .en  (enable_i),
    .d   (sync_d),
    .q   (sync_q)
  );

  assign step_s = sync_q[SW-1];
  assign edge_s = sync_q[SW-2];
  assign dir_s  = sync_q[MODE_W];
  assign mode_s = sync_q[MODE_W-1:0];
  assign policy = edge_s ? EDGE_RISE : EDGE_BOTH;

  stepacq_filter #(.LEN(FILT_LEN), .IDLE(STEP_IDLE)) u_filt (
    .clk    (clk),
    .rst    (rst),
    .en     (enable_i),
    .din    (step_s),
    .lvl_o  (filt_lvl),
    .chg_o  (filt_chg),
    .rise_o (filt_rise)
  );

  stepacq_qual #(.MODE_W(MODE_W)) u_qual (
    .clk    (clk),
    .rst    (rst),
    .en     (enable_i),
    .chg    (filt_chg),
    .rise   (filt_rise),
    .policy (policy),
    .dir_s  (dir_s),
    .mode_s (mode_s),
    .step_o (step_o),
    .dir_o  (dir_o),
    .mode_o (mode_o)
  );
endmodule

// File: rtl/stepclk_acq_chk.sv
module stepclk_acq_chk #(
  parameter int MODE_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              enable_i,
  input logic              step_o,
  input logic              dir_o,
  input logic [MODE_W-1:0] mode_o,
  input logic              filt_lvl,
  input logic              edge_s
);
  // R9: strobe lasts one cycle
  p_step_single_r9: assert property (@(posedge clk) disable iff (rst)
    step_o |=> !step_o);

  // R8: hold freezes outputs and blocks strobes
  p_hold_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(enable_i) |-> (!step_o && $stable(dir_o) && $stable(mode_o)));

  // R3: an undeferred strobe follows a filtered level change
  p_step_on_change_r3: assert property (@(posedge clk) disable iff (rst)
    (step_o && $past(enable_i, 2)) |-> ($past(filt_lvl) != $past(filt_lvl, 2)));

  // R2: in rising-only mode an undeferred strobe follows a rise
  p_rise_only_r2: assert property (@(posedge clk) disable iff (rst)
    (step_o && $past(enable_i, 2) && $past(edge_s, 2)) |-> $past(filt_lvl));

  // R6: direction change is followed by its strobe unless held
  p_dir_with_step_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(dir_o) |=> (step_o || !$past(enable_i)));
endmodule

bind stepclk_acq stepclk_acq_chk #(.MODE_W(MODE_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .enable_i (enable_i),
  .step_o   (step_o),
  .dir_o    (dir_o),
  .mode_o   (mode_o),
  .filt_lvl (filt_lvl),
  .edge_s   (edge_s)
);

// File: tb/stepclk_acq_test.sv
module stepclk_acq_test;
  localparam int N  = 8;
  localparam int MW = 2;

  logic          clk = 1'b0;
  logic          rst;
  logic          en;
  logic          raw;
  logic          esel;
  logic          dir;
  logic [MW-1:0] mode;
  logic          step_o;
  logic          dir_o;
  logic [MW-1:0] mode_o;

  int checks = 0;
  int failures = 0;
  int steps = 0;
  bit prev_step = 1'b0;
  bit done = 1'b0;
  string tag = "R1";

  always #4 clk = ~clk;

  stepclk_acq #(.FILT_LEN(N), .MODE_W(MW)) uut (
    .clk(clk), .rst(rst), .enable_i(en), .step_i(raw), .one_edge_i(esel),
    .dir_i(dir), .mode_i(mode), .step_o(step_o), .dir_o(dir_o), .mode_o(mode_o)
  );

  // Behavioural reference: sample queues and a run of recent levels
  logic          m_s1, m_s2, m_e1, m_e2, m_d1, m_d2, m_filt, m_acc, m_step, m_dir;
  logic [MW-1:0] m_mo1, m_mo2, m_mode;
  logic          hist[$];

  always @(posedge clk) begin : model
    int ones;
    logic nacc;
    if (rst) begin
      m_s1 = 1; m_s2 = 1; m_e1 = 1; m_e2 = 1; m_d1 = 0; m_d2 = 0;
      m_mo1 = 0; m_mo2 = 0; m_filt = 1; m_acc = 0; m_step = 0;
      m_dir = 0; m_mode = 0;
      hist = {};
      repeat (N) hist.push_back(1'b1);
    end else if (en) begin
      ones = 0;
      foreach (hist[i]) if (hist[i]) ones++;
      nacc = 0;
      if (ones == N && !m_filt) begin
        m_filt = 1; nacc = 1;
      end else if (ones == 0 && m_filt) begin
        m_filt = 0;
        if (!m_e2) nacc = 1;
      end
      if (nacc) begin m_dir = m_d2; m_mode = m_mo2; end
      m_step = m_acc;
      m_acc  = nacc;
      hist.push_front(m_s2); void'(hist.pop_back());
      m_s2 = m_s1; m_s1 = raw;
      m_e2 = m_e1; m_e1 = esel;
      m_d2 = m_d1; m_d1 = dir;
      m_mo2 = m_mo1; m_mo1 = mode;
    end else begin
      m_step = 0;
    end
  end

  task automatic chk(string t, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) begin
      @(negedge clk);
      if (!rst) begin
        chk({tag, " step_o"}, step_o, m_step);
        chk({tag, " dir_o"}, dir_o, m_dir);
        chk({tag, " mode_o"}, mode_o, m_mode);
        if (step_o && prev_step) chk("R9 back-to-back strobe", 1, 0);
        if (step_o) steps++;
        prev_step = step_o;
      end
    end
  endtask

  task automatic pulses(int k);
    repeat (k) begin
      raw = 0; cyc(20);
      raw = 1; cyc(20);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin : stim
    int s0;
    int cnt;
    rst = 1; en = 1; raw = 1; esel = 1; dir = 0; mode = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    tag = "R1";
    cyc(1);
    chk("R1 reset step_o", step_o, 0);
    chk("R1 reset dir_o", dir_o, 0);
    chk("R1 reset mode_o", mode_o, 0);
    cyc(20);
    chk("R1 idle-high gives no step", steps, 0);

    // R2: rising edges only
    tag = "R2";
    dir = 1; mode = 2;
    s0 = steps;
    pulses(3);
    cyc(15);
    chk("R2 three rises", steps - s0, 3);
    chk("R6 dir captured", dir_o, 1);
    chk("R6 mode captured", mode_o, 2);

    // R3: both edges
    tag = "R3";
    esel = 0; cyc(5);
    s0 = steps;
    pulses(3);
    cyc(15);
    chk("R3 six steps from three periods", steps - s0, 6);

    // R4: spike rejection and threshold
    tag = "R4";
    s0 = steps;
    repeat (4) begin raw = 0; cyc(3); raw = 1; cyc(20); end
    raw = 0; cyc(N - 1); raw = 1; cyc(20);
    chk("R4 short spikes rejected", steps - s0, 0);
    s0 = steps;
    raw = 0; cyc(N); raw = 1; cyc(N + 15);
    chk("R4 exact threshold accepted", steps - s0, 2);

    // R5: latency
    tag = "R5";
    raw = 0; cnt = 0;
    do begin cyc(1); cnt++; end while (!step_o && cnt < 40);
    chk("R5 latency in edges", cnt, N + 4);
    cyc(20);

    // R6 / R7: capture point
    tag = "R6";
    dir = 0; mode = 1; raw = 1;
    cyc(N + 10);
    chk("R6 dir with step", dir_o, 0);
    chk("R6 mode with step", mode_o, 1);
    tag = "R7";
    raw = 0; cyc(N + 1);
    dir = 1; mode = 3;
    cyc(20);
    chk("R7 late dir not captured", dir_o, 0);
    chk("R7 late mode not captured", mode_o, 1);
    dir = 0; cyc(3); dir = 1; mode = 0; cyc(10);
    chk("R7 idle dir changes ignored", dir_o, 0);
    chk("R7 idle mode changes ignored", mode_o, 1);

    // R8: hold
    tag = "R8";
    en = 0; s0 = steps;
    raw = 1; cyc(20); raw = 0; cyc(20); raw = 1; cyc(20);
    dir = 0; mode = 2;
    cyc(10);
    chk("R8 no strobes in hold", steps - s0, 0);
    chk("R8 dir frozen", dir_o, 0);
    chk("R8 mode frozen", mode_o, 1);
    en = 1; s0 = steps;
    cyc(N + 15);
    chk("R8 level changed in hold counted after release", steps - s0, 1);
    raw = 0; cyc(N + 3);
    en = 0; s0 = steps;
    cyc(6);
    chk("R8 pending strobe withheld", steps - s0, 0);
    en = 1;
    cyc(1);
    chk("R8 pending strobe on release", step_o, 1);
    cyc(10);
    chk("R9 strobe count stays single-cycle", prev_step, 0);
    finish_run();
  end
endmodule